// File: doc/BRIEF.md
# Parallel Camera Sensor Capture

This block sits at the edge of an image pipeline. It takes the raw bus of a parallel image sensor (a frame sync, a line sync, the pixel clock and an 8- or 10-bit data word) and turns it into a stream of qualified samples. Each sample carries markers for the start and end of its frame and its line. The block is clocked by the sensor's pixel clock. The FIFO and clock-domain crossing that follow it live elsewhere.

A mode input picks how samples are qualified. In line-qualified mode the line sync stays active for the whole of each line, and only pixel-clock edges seen while it is active carry data. In free-running mode the line sync is ignored. Every pixel-clock edge inside an open frame carries data, and the sensor signals idle only by stopping its clock. Each sync input has its own invert control, so sensors of either polarity can be used. A 16-bit line counter and a 16-bit pixel counter report where the most recent sample sits within its frame.

Top module: `cam_capture`

## Requirements
- R1: While reset is asserted, all strobes, markers and counters are zero. After reset, no sample is emitted until the frame sync makes an inactive-to-active transition, even if the sync is already active when reset is released.
- R2: A frame opens on a pixel-clock edge where the polarity-corrected frame sync is active and was inactive on the previous edge. With the frame invert input set to 1, this corresponds to a high-to-low transition on the raw pin.
- R3: In line-qualified mode (`gated_mode` = 1), each edge inside an open frame that sees the corrected line sync active produces a sample. On the following cycle `out_valid` is 1 and `out_data` holds the bus value taken at that edge.
- R4: In line-qualified mode, edges that see the corrected line sync inactive produce no sample (`out_valid` = 0).
- R5: In free-running mode (`gated_mode` = 0), the line sync has no effect. Every edge that sees an open frame with the corrected frame sync active produces a sample, and the edge that opens the frame is the first of these.
- R6: `out_sof` is 1 together with the first sample of each frame and at no other time. In line-qualified mode, `out_sol` is 1 together with the first sample of each line. In free-running mode, `out_sol` stays 0.
- R7: In line-qualified mode, `out_eol` is a one-cycle pulse. It follows an edge where the corrected line sync went from active to inactive while a frame was open. A line-sync pulse outside a frame produces no pulse.
- R8: `out_eof` is a one-cycle pulse. It follows an edge where the corrected frame sync went from active to inactive while a frame was open, and that edge closes the frame.
- R9: An edge that sees `gated_mode` differ from its value on the previous edge closes any open frame and produces no sample. No sample follows until the next frame opening, and the abandoned frame yields no `out_eof`.
- R10: With each sample, `line_count` holds the number of lines begun in the current frame (always 0 in free-running mode). `pixel_count` holds the 1-based position of the sample within its line (line-qualified mode) or within its frame (free-running mode).
- R11: Setting the line invert input to 1 makes the low level of the raw line sync the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock; every register samples on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gated_mode | input | 1 | 1 = line sync qualifies samples, 0 = free-running |
| vs_inv | input | 1 | Invert the frame sync before use |
| hs_inv | input | 1 | Invert the line sync before use |
| vsync | input | 1 | Raw frame sync from the sensor |
| hsync | input | 1 | Raw line sync from the sensor |
| pix_in | input | DW | Sensor data bus |
| out_valid | output | 1 | A sample is present this cycle |
| out_data | output | DW | Sample value |
| out_sof | output | 1 | First sample of a frame |
| out_sol | output | 1 | First sample of a line (line-qualified mode) |
| out_eol | output | 1 | End-of-line pulse |
| out_eof | output | 1 | End-of-frame pulse |
| line_count | output | CW | Lines begun in the current frame |
| pixel_count | output | CW | Position of the sample within its line or frame |

## Verification
The block keeps only a few state bits: the previous sync levels, the open-frame flag, the pending start-of-frame flag and the last mode. Any one of them being wrong shows up at the ports within one cycle of the next sync transition.

A stale previous-level register produces a missing or doubled marker, or a marker on the wrong sample. A wrong open-frame flag either leaks samples before a frame opens or drops the samples of a real frame. A counter fault appears on the first sample of the next line.

The bench sweeps both modes, all four polarity settings and several frame shapes. It compares every cycle's markers, and every sample's data and counters, against values derived from the frame's shape.

// File: rtl/cam_capture.sv
module cam_capture #(
  parameter int DW = 10,
  parameter int CW = 16
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          gated_mode,
  input  logic          vs_inv,
  input  logic          hs_inv,
  input  logic          vsync,
  input  logic          hsync,
  input  logic [DW-1:0] pix_in,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_sol,
  output logic          out_eol,
  output logic          out_eof,
  output logic [CW-1:0] line_count,
  output logic [CW-1:0] pixel_count
);

  logic vs_q, hs_q, mode_q, open_q, sof_pend;
  logic vs_act, hs_act, mode_chg, frame_start, vs_fall, hs_fall;
  logic open_now, take, sof_now, sol_now, line_start;

  assign vs_act      = vsync ^ vs_inv;
  assign hs_act      = hsync ^ hs_inv;
  assign mode_chg    = gated_mode != mode_q;
  assign frame_start = vs_act & ~vs_q & ~mode_chg;
  assign vs_fall     = ~vs_act & vs_q;
  assign hs_fall     = ~hs_act & hs_q;
  assign open_now    = (open_q | frame_start) & vs_act & ~mode_chg;
  assign take        = open_now & (~gated_mode | hs_act);
  assign sof_now     = take & (frame_start | sof_pend);
  assign sol_now     = take & gated_mode & (~hs_q | sof_now);
  assign line_start  = gated_mode ? sol_now : sof_now;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q        <= 1'b1;
      hs_q        <= 1'b1;
      mode_q      <= 1'b1;
      open_q      <= 1'b0;
      sof_pend    <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sof     <= 1'b0;
      out_sol     <= 1'b0;
      out_eol     <= 1'b0;
      out_eof     <= 1'b0;
      line_count  <= '0;
      pixel_count <= '0;
    end else begin
      vs_q      <= vs_act;
      hs_q      <= hs_act;
      mode_q    <= gated_mode;
      open_q    <= open_now;
      sof_pend  <= (frame_start | sof_pend) & open_now & ~take;
      out_valid <= take;
      if (take) out_data <= pix_in;
      out_sof   <= sof_now;
      out_sol   <= sol_now;
      out_eol   <= gated_mode & open_q & hs_fall & ~mode_chg;
      out_eof   <= open_q & vs_fall & ~mode_chg;
      if (frame_start)  line_count <= sol_now ? CW'(1) : '0;
      else if (sol_now) line_count <= line_count + CW'(1);
      if (take)             pixel_count <= line_start ? CW'(1) : pixel_count + CW'(1);
      else if (frame_start) pixel_count <= '0;
    end
  end

  // R6
  sof_has_sample_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R4
  gated_idle_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (gated_mode && !mode_chg && !hs_act) |=> !out_valid);

  // R7
  eol_single_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    out_eol |=> !out_eol);

  // R8
  eof_single_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    out_eof |=> !out_eof);

  // R9
  mode_drop_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    mode_chg |=> (!out_valid && !out_eof));

  // R10
  sol_count_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    out_sol |-> (pixel_count == CW'(1) && line_count != '0));

endmodule

// File: tb/cam_capture_test.sv
module cam_capture_test;
  localparam int DW = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gated_mode = 1'b1, vs_inv = 1'b0, hs_inv = 1'b0;
  logic vsync = 1'b1, hsync = 1'b1;
  logic [DW-1:0] pix_in = '0;
  logic out_valid, out_sof, out_sol, out_eol, out_eof;
  logic [DW-1:0] out_data;
  logic [CW-1:0] line_count, pixel_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cam_capture #(.DW(DW), .CW(CW)) uut (
    .pclk(clk), .rst_n(rst_n), .gated_mode(gated_mode), .vs_inv(vs_inv), .hs_inv(hs_inv),
    .vsync(vsync), .hsync(hsync), .pix_in(pix_in), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_sol(out_sol), .out_eol(out_eol), .out_eof(out_eof),
    .line_count(line_count), .pixel_count(pixel_count));

  // flags order: {valid, sof, sol, eol, eof}
  task automatic step(input logic v, input logic h, input logic [DW-1:0] d,
                      input logic [4:0] ef, input int elc, input int epc, input string req);
    logic [4:0] af;
    bit bad;
    vsync = v ^ vs_inv;
    hsync = h ^ hs_inv;
    pix_in = d;
    @(posedge clk);
    @(negedge clk);
    checks++;
    af = {out_valid, out_sof, out_sol, out_eol, out_eof};
    bad = (af != ef);
    if (ef[4]) bad = bad || out_data != d || line_count != CW'(elc) || pixel_count != CW'(epc);
    if (bad) begin
      errors++;
      $display("FAIL %s: flags=%b data=%0d lc=%0d pc=%0d expected flags=%b data=%0d lc=%0d pc=%0d",
               req, af, out_data, line_count, pixel_count, ef, d, elc, epc);
    end
  endtask

  function automatic logic [DW-1:0] pix(input int cfg, input int l, input int p);
    return DW'((cfg * 37 + l * 11 + p * 3 + 5) % (1 << DW));
  endfunction

  task automatic gated_frame(input int cfg, input int nl, input int np);
    gated_mode = 1'b1;
    step(0, 0, 0, 5'b0, 0, 0, "R9");
    step(0, 1, 0, 5'b0, 0, 0, "R7");
    step(0, 0, 0, 5'b0, 0, 0, "R7");
    step(1, 0, 7, 5'b0, 0, 0, "R2 R4");
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < np; p++)
        step(1, 1, pix(cfg, l, p), {1'b1, l == 0 && p == 0, p == 0, 2'b00}, l + 1, p + 1,
             "R2 R3 R6 R10 R11");
      step(1, 0, 3, 5'b00010, 0, 0, "R4 R7");
      step(1, 0, 9, 5'b0, 0, 0, "R4");
    end
    step(0, 0, 0, 5'b00001, 0, 0, "R8");
  endtask

  task automatic free_frame(input int cfg, input int n);
    gated_mode = 1'b0;
    step(0, 1, 0, 5'b0, 0, 0, "R9");
    step(0, 0, 0, 5'b0, 0, 0, "R5");
    for (int p = 0; p < n; p++)
      step(1, p[0], pix(cfg, 9, p), {1'b1, p == 0, 3'b000}, 0, p + 1, "R2 R5 R6 R10");
    step(0, 0, 0, 5'b00001, 0, 0, "R8");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    checks++;
    if ({out_valid, out_sof, out_sol, out_eol, out_eof} != 5'b0 || line_count != 0 || pixel_count != 0) begin
      errors++;
      $display("FAIL R1: outputs=%b lc=%0d pc=%0d expected 0 0 0",
               {out_valid, out_sof, out_sol, out_eol, out_eof}, line_count, pixel_count);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1, 1, 100, 5'b0, 0, 0, "R1");
    step(0, 0, 0, 5'b0, 0, 0, "R1");

    for (int inv = 0; inv < 4; inv++)
      for (int nl = 1; nl <= 3; nl++)
        for (int np = 1; np <= 4; np++) begin
          vs_inv = inv[0];
          hs_inv = inv[1];
          gated_frame(inv * 16 + nl * 4 + np, nl, np);
          free_frame(inv * 16 + nl * 4 + np, nl * np);
        end

    vs_inv = 1'b0;
    hs_inv = 1'b0;
    gated_mode = 1'b1;
    step(0, 0, 0, 5'b0, 0, 0, "R9");
    step(1, 0, 0, 5'b0, 0, 0, "R9");
    step(1, 1, 21, 5'b11100, 1, 1, "R9");
    step(1, 1, 22, 5'b10000, 1, 2, "R9");
    gated_mode = 1'b0;
    step(1, 1, 23, 5'b0, 0, 0, "R9");
    step(1, 1, 24, 5'b0, 0, 0, "R9");
    step(0, 0, 0, 5'b0, 0, 0, "R9");
    step(1, 0, 25, 5'b11000, 0, 1, "R9 R5");
    step(0, 0, 0, 5'b00001, 0, 0, "R9 R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule